// File: doc/BRIEF.md
# Colliding-Write Priority Resolver with Backing Store

This block is the write side of a small RAM that has several write ports, all clocked by one clock. Every port presents an address, a data word and one enable bit for each data bit. Two or more ports can target the same storage word in the same cycle. When they do, the block settles each bit in favour of the port with the larger index. It does this by clearing the enables of lower-numbered ports wherever a higher port also writes that bit. The enables that survive are driven out and applied to the storage array held inside the block.

A port can be declared wide. A wide port covers 2^`WIDE_LOG2` consecutive words in one access, and its low address bits are ignored. A collision between a wide port and a narrow port is found one sub-word at a time. The array covers absolute addresses `OFFSET` to `OFFSET+DEPTH-1`. `DEPTH` and `OFFSET` must both be multiples of 2^`WIDE_LOG2`.

Reset loads an initial image. The image is built from a fill value and a short list of records, each of which is a run of incrementing words. The whole array is visible on a flat output. Write ports accept no back-pressure: every surviving enabled bit is committed on the clock edge at which it is presented.

Top module: `mpw_resolver`

## Requirements
- R1: When ports write the same array word and the same bit in one cycle, the port with the highest index wins that bit. The highest-index port's enables are never masked.
- R2: Masking is per bit. A bit of port i stays enabled unless some port j>i addresses the same word and has that bit enabled. Bits that a higher port does not enable are still written by the lower port.
- R3: `res_en` never has a bit set that the matching `wr_en` bit does not have. Resolution does not depend on whether the address lies inside the array.
- R4: A wide port (its bit in `WIDE_MASK` is 1) writes lane k, carried on data and enable bits [k*DW +: DW], to word {address with low `WIDE_LOG2` bits cleared} + k. The low `WIDE_LOG2` address bits have no effect.
- R5: Collisions between a wide port and a narrow port are resolved lane by lane. Only the lane whose word matches is masked.
- R6: For a narrow port, data and enable bits at positions DW and above are ignored, and its `res_en` bits at those positions are 0.
- R7: An absolute address A writes array word A-`OFFSET`. A lane whose address lies outside [`OFFSET`, `OFFSET`+`DEPTH`) changes nothing.
- R8: While `rst` is high, writes are ignored and the array loads its image. The image starts as `FILL` in every word. Records r = 0, 1, 2, ... are then applied in increasing order, a later record overriding an earlier one. Word i of record r sits at `INIT_AT[r]`+i and has the value `INIT_BASE[r]`+i (mod 2^DW). Words of a record that fall outside the array are skipped.
- R9: Array bits with no surviving enable keep their value.
- R10: `mem_image` bits [k*DW +: DW] hold array word k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all write ports |
| rst | input | 1 | Synchronous reset, active high, loads the initial image |
| wr_addr | input | NPORTS*AW | Absolute address of each port; port p at [p*AW +: AW] |
| wr_en | input | NPORTS*PW | Per-bit write enables; port p at [p*PW +: PW], PW = DW<<WIDE_LOG2 |
| wr_data | input | NPORTS*PW | Write data, same layout as `wr_en` |
| res_en | output | NPORTS*PW | Enables that survive resolution, same layout |
| mem_image | output | DEPTH*DW | Current array contents, word k at [k*DW +: DW] |

## Verification
The bench concentrates on three-way collisions on one word and on partial enables that overlap. A design that masked whole words instead of single bits would drop the lower port's uncovered bits. A design with the priority order reversed would leave the low-index data in the array.

It drives a wide port whose address has its low bit set, and it collides that port against narrow ports on each of its lanes. A resolver that ignored lanes would either miss the collision or mask the wrong half.

Stimulus also puts writes on the first and last array words and on addresses just outside the array, puts junk in the unused upper lanes of narrow ports, and asserts enables throughout reset. These cases expose an off-by-one in the offset window, leakage from unused lanes, and writes that slip past reset.

// File: rtl/mpw_pkg.sv
package mpw_pkg;

  // True when an absolute word address falls inside the array window.
  function automatic logic in_window(input int unsigned addr, input int unsigned base,
                                     input int unsigned depth);
    return (addr >= base) && (addr < base + depth);
  endfunction

  // Number of words one access of a port covers.
  function automatic int unsigned lane_count(input logic is_wide, input int unsigned wlog2);
    return is_wide ? (32'd1 << wlog2) : 32'd1;
  endfunction

endpackage

// File: rtl/mpw_pair.sv
// Builds, for one lower-priority port, the mask of bits claimed by one
// higher-priority port. Lanes are compared word by word.
module mpw_pair #(
  parameter int AW       = 5,
  parameter int DW       = 4,
  parameter int WL       = 1,
  parameter int LO_LANES = 1,
  parameter int HI_LANES = 1
) (
  input  logic [AW-1:0]         lo_addr,
  input  logic [AW-1:0]         hi_addr,
  input  logic [(DW<<WL)-1:0]   hi_en,
  output logic [(DW<<WL)-1:0]   kill
);
  localparam int PW = DW << WL;

  logic [AW-1:0] lo_base;
  logic [AW-1:0] hi_base;

  assign lo_base = lo_addr & ~AW'(LO_LANES - 1);
  assign hi_base = hi_addr & ~AW'(HI_LANES - 1);

  always_comb begin
    kill = '0;
    for (int s = 0; s < LO_LANES; s++) begin
      for (int t = 0; t < HI_LANES; t++) begin
        if ((lo_base | AW'(s)) == (hi_base | AW'(t)))
          kill[s*DW +: DW] = kill[s*DW +: DW] | hi_en[t*DW +: DW];
      end
    end
  end

endmodule

// File: rtl/mpw_array.sv
// Storage array: applies resolved enables and loads the initial image on reset.
module mpw_array
  import mpw_pkg::*;
#(
  parameter int AW        = 5,
  parameter int DW        = 4,
  parameter int WL        = 1,
  parameter int NPORTS    = 3,
  parameter logic [NPORTS-1:0] WIDE_MASK = 3'b010,
  parameter int DEPTH     = 16,
  parameter int OFFSET    = 8,
  parameter logic [DW-1:0] FILL = '0,
  parameter int NINIT     = 3,
  parameter logic [NINIT-1:0][AW-1:0] INIT_AT   = {5'd22, 5'd10, 5'd6},
  parameter logic [NINIT-1:0][7:0]    INIT_LEN  = {8'd4, 8'd3, 8'd5},
  parameter logic [NINIT-1:0][DW-1:0] INIT_BASE = {4'h1, 4'hA, 4'h3}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPORTS*AW-1:0]   addr,
  input  logic [NPORTS*(DW<<WL)-1:0] en,
  input  logic [NPORTS*(DW<<WL)-1:0] data,
  output logic [DEPTH*DW-1:0]    image
);
  localparam int PW    = DW << WL;
  localparam int LANES = 1 << WL;

  function automatic logic [DEPTH*DW-1:0] build_image();
    logic [DEPTH*DW-1:0] img;
    int unsigned a;
    for (int k = 0; k < DEPTH; k++) img[k*DW +: DW] = FILL;
    for (int r = 0; r < NINIT; r++) begin
      for (int i = 0; i < int'(INIT_LEN[r]); i++) begin
        a = int'(INIT_AT[r]) + i;
        if (in_window(a, OFFSET, DEPTH))
          img[(a-OFFSET)*DW +: DW] = INIT_BASE[r] + DW'(i);
      end
    end
    return img;
  endfunction

  localparam logic [DEPTH*DW-1:0] IMAGE = build_image();

  logic [DEPTH*DW-1:0] store;
  logic [DEPTH*DW-1:0] nxt;

  always_comb begin
    int unsigned  wa;
    int unsigned  nl;
    logic [DW-1:0] m;
    logic [DW-1:0] d;
    nxt = store;
    for (int p = 0; p < NPORTS; p++) begin
      nl = lane_count(WIDE_MASK[p], WL);
      for (int s = 0; s < LANES; s++) begin
        wa = int'(addr[p*AW +: AW] & ~AW'(nl - 1)) + s;
        m  = en[p*PW + s*DW +: DW];
        d  = data[p*PW + s*DW +: DW];
        if ((s < int'(nl)) && in_window(wa, OFFSET, DEPTH))
          nxt[(wa-OFFSET)*DW +: DW] = (nxt[(wa-OFFSET)*DW +: DW] & ~m) | (d & m);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) store <= IMAGE;
    else     store <= nxt;
  end

  assign image = store;

endmodule

// File: rtl/mpw_resolver.sv
// Top: per-bit priority resolution across write ports plus the backing array.
module mpw_resolver
  import mpw_pkg::*;
#(
  parameter int AW        = 5,
  parameter int DW        = 4,
  parameter int WIDE_LOG2 = 1,
  parameter int NPORTS    = 3,
  parameter logic [NPORTS-1:0] WIDE_MASK = 3'b010,
  parameter int DEPTH     = 16,
  parameter int OFFSET    = 8,
  parameter logic [DW-1:0] FILL = '0,
  parameter int NINIT     = 3,
  parameter logic [NINIT-1:0][AW-1:0] INIT_AT   = {5'd22, 5'd10, 5'd6},
  parameter logic [NINIT-1:0][7:0]    INIT_LEN  = {8'd4, 8'd3, 8'd5},
  parameter logic [NINIT-1:0][DW-1:0] INIT_BASE = {4'h1, 4'hA, 4'h3}
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NPORTS*AW-1:0]                wr_addr,
  input  logic [NPORTS*(DW<<WIDE_LOG2)-1:0]   wr_en,
  input  logic [NPORTS*(DW<<WIDE_LOG2)-1:0]   wr_data,
  output logic [NPORTS*(DW<<WIDE_LOG2)-1:0]   res_en,
  output logic [DEPTH*DW-1:0]                 mem_image
);
  localparam int PW = DW << WIDE_LOG2;

  logic [NPORTS*NPORTS*PW-1:0] kill;

  for (genvar i = 0; i < NPORTS; i++) begin : g_res
    localparam int LI = int'(lane_count(WIDE_MASK[i], WIDE_LOG2));
    localparam logic [PW-1:0] LMASK = WIDE_MASK[i] ? {PW{1'b1}} : PW'({DW{1'b1}});
    logic [PW-1:0] acc;

    for (genvar j = 0; j < NPORTS; j++) begin : g_vs
      if (j > i) begin : g_hi
        localparam int LJ = int'(lane_count(WIDE_MASK[j], WIDE_LOG2));
        mpw_pair #(
          .AW(AW), .DW(DW), .WL(WIDE_LOG2), .LO_LANES(LI), .HI_LANES(LJ)
        ) u_pair (
          .lo_addr (wr_addr[i*AW +: AW]),
          .hi_addr (wr_addr[j*AW +: AW]),
          .hi_en   (wr_en[j*PW +: PW] & (WIDE_MASK[j] ? {PW{1'b1}} : PW'({DW{1'b1}}))),
          .kill    (kill[(i*NPORTS+j)*PW +: PW])
        );
      end else begin : g_none
        assign kill[(i*NPORTS+j)*PW +: PW] = '0;
      end
    end

    always_comb begin
      acc = '0;
      for (int j = 0; j < NPORTS; j++) acc = acc | kill[(i*NPORTS+j)*PW +: PW];
    end

    assign res_en[i*PW +: PW] = wr_en[i*PW +: PW] & LMASK & ~acc;
  end

  mpw_array #(
    .AW(AW), .DW(DW), .WL(WIDE_LOG2), .NPORTS(NPORTS), .WIDE_MASK(WIDE_MASK),
    .DEPTH(DEPTH), .OFFSET(OFFSET), .FILL(FILL), .NINIT(NINIT),
    .INIT_AT(INIT_AT), .INIT_LEN(INIT_LEN), .INIT_BASE(INIT_BASE)
  ) u_array (
    .clk   (clk),
    .rst   (rst),
    .addr  (wr_addr),
    .en    (res_en),
    .data  (wr_data),
    .image (mem_image)
  );

endmodule

// File: rtl/mpw_resolver_chk.sv
module mpw_resolver_chk
  import mpw_pkg::*;
#(
  parameter int AW        = 5,
  parameter int DW        = 4,
  parameter int WIDE_LOG2 = 1,
  parameter int NPORTS    = 3,
  parameter logic [NPORTS-1:0] WIDE_MASK = 3'b010,
  parameter int DEPTH     = 16,
  parameter int OFFSET    = 8
) (
  input logic                              clk,
  input logic                              rst,
  input logic [NPORTS*AW-1:0]              wr_addr,
  input logic [NPORTS*(DW<<WIDE_LOG2)-1:0] wr_en,
  input logic [NPORTS*(DW<<WIDE_LOG2)-1:0] wr_data,
  input logic [NPORTS*(DW<<WIDE_LOG2)-1:0] res_en,
  input logic [DEPTH*DW-1:0]               mem_image
);
  localparam int PW  = DW << WIDE_LOG2;
  localparam int TOP = NPORTS - 1;
  localparam int LT  = int'(lane_count(WIDE_MASK[TOP], WIDE_LOG2));

  assert_subset_R3: assert property (@(posedge clk) disable iff (rst)
    (res_en & ~wr_en) == '0);

  assert_top_kept_R1: assert property (@(posedge clk) disable iff (rst)
    res_en[TOP*PW +: DW] == wr_en[TOP*PW +: DW]);

  for (genvar i = 0; i < NPORTS; i++) begin : g_pc
    if (!WIDE_MASK[i]) begin : g_nar
      assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        res_en[i*PW + DW +: PW-DW] == '0);
    end
    for (genvar j = i + 1; j < NPORTS; j++) begin : g_hi
      localparam int LI = int'(lane_count(WIDE_MASK[i], WIDE_LOG2));
      localparam int LJ = int'(lane_count(WIDE_MASK[j], WIDE_LOG2));
      logic [AW-1:0] bi, bj;
      assign bi = wr_addr[i*AW +: AW] & ~AW'(LI - 1);
      assign bj = wr_addr[j*AW +: AW] & ~AW'(LJ - 1);
      assert_bit_mask_R2: assert property (@(posedge clk) disable iff (rst)
        (bi == bj) |-> ((res_en[i*PW +: DW] & wr_en[j*PW +: DW]) == '0));
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (res_en == '0) |=> $stable(mem_image));

  // Tracks the top port's lane-0 write to confirm it lands next cycle.
  logic [AW-1:0] top_base;
  logic          top_hit;
  logic          last_hit;
  int unsigned   last_idx;
  logic [DW-1:0] last_en, last_dat;

  assign top_base = wr_addr[TOP*AW +: AW] & ~AW'(LT - 1);
  assign top_hit  = (|wr_en[TOP*PW +: DW]) && in_window(int'(top_base), OFFSET, DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_hit <= 1'b0;
      last_idx <= 0;
      last_en  <= '0;
      last_dat <= '0;
    end else begin
      last_hit <= top_hit;
      last_idx <= int'(top_base) - OFFSET;
      last_en  <= wr_en[TOP*PW +: DW];
      last_dat <= wr_data[TOP*PW +: DW];
    end
  end

  assert_top_lands_R1: assert property (@(posedge clk) disable iff (rst)
    last_hit |-> ((mem_image[last_idx*DW +: DW] & last_en) == (last_dat & last_en)));

endmodule

bind mpw_resolver mpw_resolver_chk #(
  .AW(AW), .DW(DW), .WIDE_LOG2(WIDE_LOG2), .NPORTS(NPORTS),
  .WIDE_MASK(WIDE_MASK), .DEPTH(DEPTH), .OFFSET(OFFSET)
) u_chk (.*);

// File: tb/mpw_resolver_test.sv
module mpw_resolver_test;
  localparam int NP = 3;
  localparam int DW = 4;
  localparam int PW = 8;
  localparam int AW = 5;
  localparam int DEPTH = 16;
  localparam int OFF = 8;

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] ad [NP];
  logic [PW-1:0] en [NP];
  logic [PW-1:0] dt [NP];
  logic [NP*AW-1:0] wr_addr;
  logic [NP*PW-1:0] wr_en, wr_data, res_en;
  logic [DEPTH*DW-1:0] mem_image;
  logic [DW-1:0] model [DEPTH];
  int checks = 0;
  int fails  = 0;

  assign wr_addr = {ad[2], ad[1], ad[0]};
  assign wr_en   = {en[2], en[1], en[0]};
  assign wr_data = {dt[2], dt[1], dt[0]};

  always #5 clk = ~clk;

  mpw_resolver uut (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_en(wr_en), .wr_data(wr_data),
    .res_en(res_en), .mem_image(mem_image)
  );

  // Port 1 is the only wide port (two lanes).
  function automatic int lanes(int p);
    return (p == 1) ? 2 : 1;
  endfunction

  function automatic int word_of(int p, int s);
    return (int'(ad[p]) & ~(lanes(p) - 1)) + s;
  endfunction

  function automatic logic [PW-1:0] exp_eff(int p);
    logic [PW-1:0] r;
    logic hit;
    r = '0;
    for (int s = 0; s < lanes(p); s++)
      for (int b = 0; b < DW; b++)
        if (en[p][s*DW+b]) begin
          hit = 1'b0;
          for (int q = p + 1; q < NP; q++)
            for (int t = 0; t < lanes(q); t++)
              if (word_of(p, s) == word_of(q, t) && en[q][t*DW+b]) hit = 1'b1;
          if (!hit) r[s*DW+b] = 1'b1;
        end
    return r;
  endfunction

  // Higher index applied last, so it wins every bit it writes.
  task automatic model_write();
    int w;
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < lanes(p); s++) begin
        w = word_of(p, s);
        if (w >= OFF && w < OFF + DEPTH)
          for (int b = 0; b < DW; b++)
            if (en[p][s*DW+b]) model[w-OFF][b] = dt[p][s*DW+b];
      end
  endtask

  task automatic check_image(string req);
    for (int k = 0; k < DEPTH; k++) begin
      checks++;
      if (mem_image[k*DW +: DW] !== model[k]) begin
        fails++;
        $display("FAIL %s R10 word %0d: actual %h expected %h", req, k,
                 mem_image[k*DW +: DW], model[k]);
      end
    end
  endtask

  task automatic check_eff(string req);
    for (int p = 0; p < NP; p++) begin
      checks++;
      if (res_en[p*PW +: PW] !== exp_eff(p)) begin
        fails++;
        $display("FAIL %s res_en port %0d: actual %h expected %h", req, p,
                 res_en[p*PW +: PW], exp_eff(p));
      end
    end
  endtask

  // Called at a negative edge with inputs already set.
  task automatic cycle(string req);
    #1 check_eff(req);
    model_write();
    @(posedge clk);
    #1 check_image(req);
    @(negedge clk);
  endtask

  task automatic set_port(int p, int a, logic [PW-1:0] e, logic [PW-1:0] d);
    ad[p] = AW'(a);
    en[p] = e;
    dt[p] = d;
  endtask

  task automatic idle();
    for (int p = 0; p < NP; p++) set_port(p, 0, '0, '0);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R8: image built from fill 0 and records {6,len5,base3},{10,len3,baseA},{22,len4,base1}
    for (int k = 0; k < DEPTH; k++) model[k] = '0;
    for (int i = 0; i < 5; i++) if (6 + i >= OFF) model[6+i-OFF] = DW'(3 + i);
    for (int i = 0; i < 3; i++) model[10+i-OFF] = DW'(4'hA + i);
    for (int i = 0; i < 4; i++) if (22 + i < OFF + DEPTH) model[22+i-OFF] = DW'(1 + i);

    rst = 1'b1;
    for (int p = 0; p < NP; p++) set_port(p, 9 + p, '1, 8'h5A);
    repeat (3) @(posedge clk);
    #1 check_image("R8 reset image, writes ignored");
    @(negedge clk);
    rst = 1'b0;
    idle();
    cycle("R9 idle hold");

    // R1: all ports on word 8, full enables
    set_port(0, 8, 8'h0F, 8'h01);
    set_port(1, 8, 8'hFF, 8'h32);
    set_port(2, 8, 8'h0F, 8'h04);
    cycle("R1 three-way collision");

    // R2: partial overlap on word 12
    idle();
    set_port(0, 12, 8'h0F, 8'h05);
    set_port(2, 12, 8'h03, 8'h0A);
    cycle("R2 partial enables");

    // R4: wide port with odd address covers 12 and 13
    idle();
    set_port(1, 13, 8'hFF, 8'h9E);
    cycle("R4 wide low address bit ignored");

    // R5: wide lane 1 (word 15) vs port 2; port 0 on lane 0 word 14
    idle();
    set_port(0, 14, 8'h0F, 8'h07);
    set_port(1, 14, 8'hFF, 8'h3C);
    set_port(2, 15, 8'h06, 8'h09);
    cycle("R5 wide vs narrow per lane");

    // R6: junk in upper lanes of narrow ports
    idle();
    set_port(0, 11, 8'hFF, 8'hF2);
    set_port(2, 9, 8'hF0, 8'hE0);
    cycle("R6 narrow upper lanes ignored");

    // R7: window edges and outside addresses
    idle();
    set_port(0, 7, 8'h0F, 8'h0F);
    set_port(1, 24, 8'hFF, 8'hFF);
    set_port(2, 23, 8'h0F, 8'h0E);
    cycle("R7 window edges");
    idle();
    set_port(0, 8, 8'h0F, 8'h0D);
    set_port(1, 6, 8'hFF, 8'h77);
    set_port(2, 31, 8'h0F, 8'h0B);
    cycle("R7 low edge and outside");

    idle();
    cycle("R9 hold after writes");

    // R3: sweep of enable patterns on shared words, then random collisions
    for (int n = 0; n < 64; n++) begin
      set_port(0, 8 + (n % 2), PW'(n), PW'(n * 7));
      set_port(1, 8, PW'(~n), PW'(n * 13));
      set_port(2, 9 - (n % 2), PW'(n * 3), PW'(n * 5));
      cycle("R2 R3 enable sweep");
    end
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < NP; p++)
        set_port(p, (n % 37 == 0) ? $urandom_range(0, 31) : $urandom_range(8, 11),
                 PW'($urandom), PW'($urandom));
      cycle("R1 R2 random collisions");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule